// File: doc/BRIEF.md
# Time-Indexed Prescheduling Line Buffer

This block holds instruction tags in a ring of time-indexed lines before they reach the issue window. An outside scheduler picks a line for each new tag and presents the tag on the insert port. The block takes the tag unless that line is already full. One line at a time is active. Each cycle, tags leave the head of the active line in the order they were inserted and move to the issue buffer. The number moved is limited by the free slots the issue buffer reports and by a per-cycle lane count.

When the active line holds nothing at the start of a cycle, the active pointer steps to the next line, wrapping around the ring, and no tag moves in that cycle. A line that empties through promotion stays active until the following cycle, and the pointer steps on then. The block reports the active index, the occupancy of every line and the total number of tags it holds.

Top module: `prescheduler`

## Requirements
- R1: After reset the active index is 0, every line is empty, the total count is 0, no promotion lane is valid, and an insert to line 0 is offered ready.
- R2: `ins_ready` is high exactly when `ins_line` names a line holding fewer than LINE_DEPTH tags. An insert with `ins_valid` high and `ins_ready` low changes no occupancy and no total.
- R3: When the active line is empty, the active index becomes (index+1) mod NUM_LINES at the next clock edge, so NUM_LINES-1 wraps to 0. No lane is valid in that cycle.
- R4: When the active line is not empty, n = min(occupancy of the active line, `ib_free`, PROMO_W) tags are promoted in that cycle. Lanes 0..n-1 of `prom_valid` are high, the others are low, and lane k carries its tag in `prom_tags[k*TAG_W +: TAG_W]`.
- R5: Tags leave a line in the order they were inserted, across lanes within a cycle and across cycles. Lane 0 always carries the oldest tag.
- R6: While the active line is not empty at the start of a cycle, the active index does not change at that cycle's edge. This holds when no lane can be promoted and when promotion empties the line.
- R7: A line's occupancy changes at each edge by +1 for an accepted insert into it and by minus the number of its tags promoted. It never exceeds LINE_DEPTH. Line i is reported in `line_occ[i*OCC_W +: OCC_W]`, with OCC_W = clog2(LINE_DEPTH+1).
- R8: `total_count` equals the sum of all line occupancies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request |
| ins_line | input | LINE_W | Target line of the insert |
| ins_tag | input | TAG_W | Tag to insert |
| ins_ready | output | 1 | Target line has room |
| ib_free | input | FREE_W | Free slots in the issue buffer this cycle |
| prom_valid | output | PROMO_W | Valid flag per promotion lane, lane 0 oldest |
| prom_tags | output | PROMO_W*TAG_W | Promoted tags, lane k at bits k*TAG_W |
| active_idx | output | LINE_W | Index of the active line |
| line_occ | output | NUM_LINES*OCC_W | Occupancy of every line |
| total_count | output | TOT_W | Total tags held |

## Verification
The assertions assume that `ib_free` never overstates the room in the issue buffer. They also assume that every lane offered is taken at the same edge, because the block has no per-lane back-pressure. They further assume that `ins_line` stays below NUM_LINES, so the indexed occupancy is always a real line. The stimulus sets `ib_free` only to small constants no larger than the issue-buffer depth and targets only existing lines. Its scenarios are ordered so that the expected contents of each line and the position of the active pointer can be worked out from the inserts alone.

// File: rtl/psl_pkg.sv
package psl_pkg;

    localparam int unsigned DEF_NUM_LINES  = 8;
    localparam int unsigned DEF_LINE_DEPTH = 4;
    localparam int unsigned DEF_TAG_W      = 6;
    localparam int unsigned DEF_PROMO_W    = 2;
    localparam int unsigned DEF_IB_DEPTH   = 8;

    // What the active line does this cycle
    typedef enum logic [1:0] {
        ACT_SKIP,   // empty: step the pointer, move nothing
        ACT_STALL,  // holds tags, issue buffer has no room
        ACT_DRAIN   // holds tags, promote some
    } act_mode_e;

    function automatic int min3(input int a, input int b, input int c);
        int m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/psl_line.sv
// One scheduling line: a FIFO with a single push and a multi-entry pop.
module psl_line #(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned PROMO_W = 2,
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned OCC_W  = $clog2(DEPTH + 1),
    localparam int unsigned PN_W   = $clog2(PROMO_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [TAG_W-1:0]           push_tag,
    input  logic [PN_W-1:0]            pop_n,
    output logic [OCC_W-1:0]           occ,
    output logic [PROMO_W*TAG_W-1:0]   peek
);

    logic [TAG_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_tag;
                wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            occ    <= occ + OCC_W'(push) - OCC_W'(pop_n);
        end
    end

    // Head entries, oldest in lane 0
    always_comb begin
        for (int k = 0; k < int'(PROMO_W); k++) begin
            peek[k*TAG_W +: TAG_W] = mem[rd_ptr + PTR_W'(k)];
        end
    end

endmodule

// File: rtl/psl_promote.sv
// Active-line pointer and promotion count.
module psl_promote import psl_pkg::*; #(
    parameter int unsigned NUM_LINES  = 8,
    parameter int unsigned LINE_DEPTH = 4,
    parameter int unsigned PROMO_W    = 2,
    parameter int unsigned IB_DEPTH   = 8,
    localparam int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int unsigned OCC_W     = $clog2(LINE_DEPTH + 1),
    localparam int unsigned FREE_W    = $clog2(IB_DEPTH + 1),
    localparam int unsigned PN_W      = $clog2(PROMO_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OCC_W-1:0]    act_occ,
    input  logic [FREE_W-1:0]   ib_free,
    output logic [LINE_W-1:0]   active,
    output logic [PN_W-1:0]     pop_n,
    output logic [PROMO_W-1:0]  lane_vld
);

    localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

    act_mode_e mode;
    int        n;

    always_comb begin
        if (act_occ == '0)      mode = ACT_SKIP;
        else if (ib_free == '0) mode = ACT_STALL;
        else                    mode = ACT_DRAIN;

        n = (mode == ACT_DRAIN) ? min3(int'(act_occ), int'(ib_free), int'(PROMO_W)) : 0;
        pop_n = PN_W'(n);
        for (int k = 0; k < int'(PROMO_W); k++) begin
            lane_vld[k] = (k < n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (mode == ACT_SKIP) begin
            active <= (active == LAST) ? '0 : active + LINE_W'(1);
        end
    end

endmodule

// File: rtl/prescheduler.sv
module prescheduler import psl_pkg::*; #(
    parameter int unsigned NUM_LINES  = DEF_NUM_LINES,
    parameter int unsigned LINE_DEPTH = DEF_LINE_DEPTH,
    parameter int unsigned TAG_W      = DEF_TAG_W,
    parameter int unsigned PROMO_W    = DEF_PROMO_W,
    parameter int unsigned IB_DEPTH   = DEF_IB_DEPTH,
    localparam int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int unsigned OCC_W     = $clog2(LINE_DEPTH + 1),
    localparam int unsigned FREE_W    = $clog2(IB_DEPTH + 1),
    localparam int unsigned TOT_W     = $clog2(NUM_LINES * LINE_DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ins_valid,
    input  logic [LINE_W-1:0]            ins_line,
    input  logic [TAG_W-1:0]             ins_tag,
    output logic                         ins_ready,
    input  logic [FREE_W-1:0]            ib_free,
    output logic [PROMO_W-1:0]           prom_valid,
    output logic [PROMO_W*TAG_W-1:0]     prom_tags,
    output logic [LINE_W-1:0]            active_idx,
    output logic [NUM_LINES*OCC_W-1:0]   line_occ,
    output logic [TOT_W-1:0]             total_count
);

    localparam int unsigned PN_W = $clog2(PROMO_W + 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(LINE_DEPTH);

    logic [OCC_W-1:0]          occ_a  [NUM_LINES];
    logic [PROMO_W*TAG_W-1:0]  peek_a [NUM_LINES];
    logic [OCC_W-1:0]          act_occ, tgt_occ;
    logic [PN_W-1:0]           pop_n;
    logic                      accept;

    assign accept = ins_valid & ins_ready;

    for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_line
        logic            push_g;
        logic [PN_W-1:0] pop_g;

        assign push_g = accept && (ins_line == LINE_W'(g));
        assign pop_g  = (active_idx == LINE_W'(g)) ? pop_n : '0;

        psl_line #(
            .DEPTH   (LINE_DEPTH),
            .TAG_W   (TAG_W),
            .PROMO_W (PROMO_W)
        ) u_line (
            .clk      (clk),
            .rst      (rst),
            .push     (push_g),
            .push_tag (ins_tag),
            .pop_n    (pop_g),
            .occ      (occ_a[g]),
            .peek     (peek_a[g])
        );

        assign line_occ[g*OCC_W +: OCC_W] = occ_a[g];
    end

    // Select the active line and the insert target
    always_comb begin
        act_occ   = '0;
        prom_tags = '0;
        tgt_occ   = FULL_OCC;
        for (int i = 0; i < int'(NUM_LINES); i++) begin
            if (active_idx == LINE_W'(i)) begin
                act_occ   = occ_a[i];
                prom_tags = peek_a[i];
            end
            if (ins_line == LINE_W'(i)) begin
                tgt_occ = occ_a[i];
            end
        end
    end

    assign ins_ready = (tgt_occ < FULL_OCC);

    psl_promote #(
        .NUM_LINES  (NUM_LINES),
        .LINE_DEPTH (LINE_DEPTH),
        .PROMO_W    (PROMO_W),
        .IB_DEPTH   (IB_DEPTH)
    ) u_promote (
        .clk      (clk),
        .rst      (rst),
        .act_occ  (act_occ),
        .ib_free  (ib_free),
        .active   (active_idx),
        .pop_n    (pop_n),
        .lane_vld (prom_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) total_count <= '0;
        else     total_count <= total_count + TOT_W'(accept) - TOT_W'(pop_n);
    end

endmodule

// File: rtl/psl_chk.sv
module psl_chk #(
    parameter int unsigned NUM_LINES  = 8,
    parameter int unsigned LINE_DEPTH = 4,
    parameter int unsigned TAG_W      = 6,
    parameter int unsigned PROMO_W    = 2,
    parameter int unsigned IB_DEPTH   = 8,
    localparam int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int unsigned OCC_W     = $clog2(LINE_DEPTH + 1),
    localparam int unsigned FREE_W    = $clog2(IB_DEPTH + 1),
    localparam int unsigned TOT_W     = $clog2(NUM_LINES * LINE_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         ins_valid,
    input logic [LINE_W-1:0]            ins_line,
    input logic [TAG_W-1:0]             ins_tag,
    input logic                         ins_ready,
    input logic [FREE_W-1:0]            ib_free,
    input logic [PROMO_W-1:0]           prom_valid,
    input logic [PROMO_W*TAG_W-1:0]     prom_tags,
    input logic [LINE_W-1:0]            active_idx,
    input logic [NUM_LINES*OCC_W-1:0]   line_occ,
    input logic [TOT_W-1:0]             total_count
);

    logic [OCC_W-1:0] act_occ, tgt_occ;
    int               occ_sum;
    logic             unused_ok;

    assign unused_ok = ^{ins_tag, prom_tags};

    always_comb begin
        act_occ = line_occ[int'(active_idx)*OCC_W +: OCC_W];
        tgt_occ = line_occ[int'(ins_line)*OCC_W +: OCC_W];
        occ_sum = 0;
        for (int i = 0; i < int'(NUM_LINES); i++) begin
            occ_sum += int'(line_occ[i*OCC_W +: OCC_W]);
        end
    end

    function automatic logic [LINE_W-1:0] next_line(input logic [LINE_W-1:0] a);
        return (int'(a) == int'(NUM_LINES) - 1) ? '0 : a + LINE_W'(1);
    endfunction

    p_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready) |=>
            (line_occ[int'($past(ins_line))*OCC_W +: OCC_W] <= $past(tgt_occ)));

    p_skip_step_r3: assert property (@(posedge clk) disable iff (rst)
        (act_occ == '0) |=> (active_idx == next_line($past(active_idx))));

    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (act_occ == '0) |-> (prom_valid == '0));

    p_lane_cap_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(prom_valid) <= int'(act_occ)) && ($countones(prom_valid) <= int'(ib_free)));

    p_lane_packed_r4: assert property (@(posedge clk) disable iff (rst)
        ((prom_valid & (prom_valid + PROMO_W'(1))) == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (act_occ != '0) |=> $stable(active_idx));

    p_total_r8: assert property (@(posedge clk) disable iff (rst)
        int'(total_count) == occ_sum);

    for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_occ
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
            int'(line_occ[g*OCC_W +: OCC_W]) <= int'(LINE_DEPTH));
    end

endmodule

bind prescheduler psl_chk #(
    .NUM_LINES  (NUM_LINES),
    .LINE_DEPTH (LINE_DEPTH),
    .TAG_W      (TAG_W),
    .PROMO_W    (PROMO_W),
    .IB_DEPTH   (IB_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ins_valid   (ins_valid),
    .ins_line    (ins_line),
    .ins_tag     (ins_tag),
    .ins_ready   (ins_ready),
    .ib_free     (ib_free),
    .prom_valid  (prom_valid),
    .prom_tags   (prom_tags),
    .active_idx  (active_idx),
    .line_occ    (line_occ),
    .total_count (total_count)
);

// File: tb/tb_prescheduler.sv
`timescale 1ns/1ps
module tb_prescheduler;

    localparam int NL    = 8;
    localparam int LD    = 4;
    localparam int TW    = 6;
    localparam int PW    = 2;
    localparam int OW    = 3;
    localparam int LW    = 3;
    localparam int FW    = 4;
    localparam int TOTW  = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ins_valid = 1'b0;
    logic [LW-1:0]   ins_line = '0;
    logic [TW-1:0]   ins_tag = '0;
    logic            ins_ready;
    logic [FW-1:0]   ib_free = '0;
    logic [PW-1:0]   prom_valid;
    logic [PW*TW-1:0] prom_tags;
    logic [LW-1:0]   active_idx;
    logic [NL*OW-1:0] line_occ;
    logic [TOTW-1:0] total_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prescheduler dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_line(ins_line),
        .ins_tag(ins_tag), .ins_ready(ins_ready), .ib_free(ib_free),
        .prom_valid(prom_valid), .prom_tags(prom_tags), .active_idx(active_idx),
        .line_occ(line_occ), .total_count(total_count)
    );

    function automatic int occ_of(input int i);
        return int'(line_occ[i*OW +: OW]);
    endfunction

    function automatic int lane_tag(input int k);
        return int'(prom_tags[k*TW +: TW]);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // advance one edge, settle 5 ns past it
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1", "active", int'(active_idx), 0);
        chk("R1", "total", int'(total_count), 0);
        chk("R1", "line_occ", int'(line_occ == '0), 1);
        chk("R1", "prom_valid", int'(prom_valid), 0);
        chk("R1", "ins_ready", int'(ins_ready), 1);
    endtask

    task automatic t_rotate();
        int a;
        a = int'(active_idx);
        for (int i = 0; i < 10; i++) begin
            chk("R3", "no promotion on empty line", int'(prom_valid), 0);
            tick();
            chk("R3", "pointer step", int'(active_idx), (a + 1) % NL);
            a = int'(active_idx);
        end
    endtask

    task automatic t_fill_reject();
        ib_free = '0;
        for (int k = 0; k < LD; k++) begin
            ins_line = 3'd5; ins_tag = TW'(10 + k); ins_valid = 1'b1;
            #1 chk("R2", "ready with room", int'(ins_ready), 1);
            tick();
        end
        ins_valid = 1'b0;
        #1;
        chk("R7", "occ line 5", occ_of(5), 4);
        chk("R8", "total", int'(total_count), 4);
        ins_line = 3'd5; ins_tag = TW'(14); ins_valid = 1'b1;
        #1 chk("R2", "ready when full", int'(ins_ready), 0);
        tick();
        ins_valid = 1'b0;
        #1;
        chk("R2", "occ after refusal", occ_of(5), 4);
        chk("R2", "total after refusal", int'(total_count), 4);
    endtask

    task automatic t_drain();
        for (int i = 0; i < 2 * NL && active_idx != 3'd5; i++) tick();
        chk("R6", "parked on line 5", int'(active_idx), 5);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6", "stall without room", int'(active_idx), 5);
            chk("R4", "no lanes without room", int'(prom_valid), 0);
        end
        ib_free = FW'(1);
        #1;
        chk("R4", "one lane by ib_free", int'(prom_valid), 1);
        chk("R5", "lane0 oldest", lane_tag(0), 10);
        tick();
        chk("R7", "occ after 1", occ_of(5), 3);
        ib_free = FW'(3);
        #1;
        chk("R4", "capped at PROMO_W", int'(prom_valid), 3);
        chk("R5", "lane0", lane_tag(0), 11);
        chk("R5", "lane1", lane_tag(1), 12);
        tick();
        chk("R7", "occ after 2", occ_of(5), 1);
        #1;
        chk("R4", "capped by occupancy", int'(prom_valid), 1);
        chk("R5", "last tag", lane_tag(0), 13);
        tick();
        chk("R7", "occ drained", occ_of(5), 0);
        chk("R6", "hold on draining edge", int'(active_idx), 5);
        chk("R8", "total drained", int'(total_count), 0);
        tick();
        chk("R3", "step after drain", int'(active_idx), 6);
    endtask

    task automatic t_wrap_concurrent();
        ib_free = '0;
        ins_line = 3'd7; ins_tag = TW'(20); ins_valid = 1'b1;
        tick();
        chk("R3", "step 6 to 7", int'(active_idx), 7);
        ins_line = 3'd7; ins_tag = TW'(21);
        tick();
        chk("R6", "hold on 7", int'(active_idx), 7);
        ins_line = 3'd0; ins_tag = TW'(30);
        tick();
        ins_valid = 1'b0;
        #1;
        chk("R7", "occ line 7", occ_of(7), 2);
        chk("R7", "occ line 0", occ_of(0), 1);
        chk("R8", "total", int'(total_count), 3);
        ib_free = FW'(8);
        #1;
        chk("R4", "two lanes", int'(prom_valid), 3);
        chk("R5", "lane0 line7", lane_tag(0), 20);
        chk("R5", "lane1 line7", lane_tag(1), 21);
        tick();
        chk("R6", "hold after emptying 7", int'(active_idx), 7);
        tick();
        chk("R3", "wrap 7 to 0", int'(active_idx), 0);
        #1;
        chk("R4", "line0 one lane", int'(prom_valid), 1);
        chk("R5", "line0 tag", lane_tag(0), 30);
        ins_line = 3'd0; ins_tag = TW'(31); ins_valid = 1'b1;
        #1 chk("R2", "ready on active line", int'(ins_ready), 1);
        tick();
        ins_valid = 1'b0;
        #1;
        chk("R7", "push and pop same edge", occ_of(0), 1);
        chk("R8", "total", int'(total_count), 1);
        chk("R5", "newer tag next", lane_tag(0), 31);
        tick();
        chk("R7", "line0 empty", occ_of(0), 0);
        tick();
        chk("R3", "step 0 to 1", int'(active_idx), 1);
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_fill_reject();
        t_drain();
        t_wrap_concurrent();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule